// File: doc/BRIEF.md
# Bit-manipulation integer ALU

A purely combinational 64-bit integer arithmetic and logic unit for a 64-bit core that implements the bit-manipulation extensions. It takes a 7-bit operation code and two operands. In the same cycle it returns a 64-bit result and a branch-taken flag. The three upper opcode bits select an operation class: shift/single-bit, 32-bit word, add, subtract/compare, logic, misc, logic-reduced and branch. The lower four bits select the variant inside the class.

The unit is built from four sub-blocks:
- a shift/rotate/single-bit unit;
- an arithmetic unit, which holds the one subtractor shared by sub, the compares, min/max and the branch comparisons;
- a logic/permutation unit;
- a branch evaluator.

The top level selects the sub-block from the class field. Any opcode that no sub-block recognises gives a zero result and a low flag.

The block holds no state, so it has no states or transitions. The "state" in this project is the operation class field, decoded by a unique case over an enumerated type.

Top module: `bmu_alu`

## Requirements
- R1: Class 000 shifts use src_b[5:0] as the shift amount. The opcodes are sll 0000001, srl 0000101, sra 0000111 (arithmetic), rol 0001001, ror 0001011 and slli.uw 0000000. slli.uw shifts the zero-extended src_a[31:0] left.
- R2: The single-bit operations take the bit index from src_b[5:0]. The opcodes are bclr 0000010, bset 0000011, binv 0000100 (toggle the bit) and bext 0000110. bext returns the indexed bit of src_a in bit 0, with zeros above it.
- R3: The word operations sign-extend bit 31 of a 32-bit result into bits 63:32. The opcodes are addw 0010000, subw 0010010, sllw 0011000, srlw 0011001 and sraw 0011010. The word shifts use src_b[4:0] and shift only src_a[31:0].
- R4: The add group computes add 0100001 as src_a+src_b and add.uw 0100000 as zext(src_a[31:0])+src_b. The shift-add opcodes add (x<<k) to src_b: sh1add.uw 0101000, sh1add 0101001, sh2add.uw 0101010, sh2add 0101011, sh3add.uw 0101100, sh3add 0101101 and sh4add 0101111. For these, k is 1, 2, 3 or 4. In the odd opcodes x is src_a; in the even (.uw) opcodes x is zext(src_a[31:0]).
- R5: Opcodes 0100100 to 0100111 compute (src_a >> N) + src_b, with a logical shift and N = 29, 30, 31, 32 in that order.
- R6: The subtract group is sub 0110000, sltu 0110001, slt 0110010, maxu 0110100, minu 0110101, max 0110110 and min 0110111. sltu and slt return 0 or 1.
- R7: The logic opcodes are and 1000000, andn 1000001, or 1000010, orn 1000011, xor 1000100 and xnor 1000101. When bit 0 is set, ~src_b replaces src_b. orcb 1000110 sets each byte of src_a to 0xFF if that byte is nonzero and to 0x00 otherwise.
- R8: The misc opcodes are:
  - sext.b 1001000 and sext.h 1001010;
  - packh 1001001, giving zext({b[7:0],a[7:0]});
  - packw 1001011, giving sext({b[15:0],a[15:0]});
  - revb 1010000, which reverses the bits within each byte;
  - rev8 1010001, which reverses the byte order;
  - pack 1010010, giving {b[31:0],a[31:0]}.
- R9: In class 110 the opcodes 1100000 to 1100111 use bits [2:1] to pick and/or/xor/orcb. When bit 0 is clear they return bit 0 of that value. When bit 0 is set they return its low 16 bits zero-extended.
- R10: The branch opcodes use bits [3:2] as the compare type: 00 equal, 10 signed less-than, 11 unsigned less-than. Bit 1 inverts the outcome. The opcodes are beq 1110000, bne 1110010, blt 1111000, bge 1111010, bltu 1111100 and bgeu 1111110.
- R11: br_taken is 0 for every opcode outside class 111. Every opcode in class 111 gives result 0.
- R12: Every opcode not listed above gives result 0 and br_taken 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 7 | Operation code: class in [6:4], variant in [3:0] |
| src_a | input | XLEN | First operand |
| src_b | input | XLEN | Second operand, also the shift amount or bit index |
| result | output | XLEN | Operation result, zero for branch and unlisted opcodes |
| br_taken | output | 1 | Branch condition outcome, branch opcodes only |

## Verification
The compare results (slt, sltu) and the branch flag (blt, bge, bltu, bgeu) both come from the borrow and sign of one subtractor. A fault in that path can therefore show up in either output.

The bench sweeps every one of the 128 opcodes over corner and pseudo-random operand pairs. It then replays each pair as slt followed by blt and bge, and as sltu followed by bltu and bgeu. It requires that blt and bltu raise the flag exactly when the matching compare returned 1, and that bge and bgeu raise it exactly when it returned 0. Each value is also checked against an arithmetic model kept in the bench.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    typedef enum logic [2:0] {
        CLS_SHIFT  = 3'b000,
        CLS_WORD   = 3'b001,
        CLS_ADD    = 3'b010,
        CLS_SUB    = 3'b011,
        CLS_LOGIC  = 3'b100,
        CLS_MISC   = 3'b101,
        CLS_REDUCE = 3'b110,
        CLS_BRANCH = 3'b111
    } op_class_e;

    // shift / single-bit class
    localparam logic [6:0] OP_SLLIUW = 7'b0000000;
    localparam logic [6:0] OP_SLL    = 7'b0000001;
    localparam logic [6:0] OP_BCLR   = 7'b0000010;
    localparam logic [6:0] OP_BSET   = 7'b0000011;
    localparam logic [6:0] OP_BINV   = 7'b0000100;
    localparam logic [6:0] OP_SRL    = 7'b0000101;
    localparam logic [6:0] OP_BEXT   = 7'b0000110;
    localparam logic [6:0] OP_SRA    = 7'b0000111;
    localparam logic [6:0] OP_ROL    = 7'b0001001;
    localparam logic [6:0] OP_ROR    = 7'b0001011;

    // word class
    localparam logic [6:0] OP_ADDW   = 7'b0010000;
    localparam logic [6:0] OP_SUBW   = 7'b0010010;
    localparam logic [6:0] OP_SLLW   = 7'b0011000;
    localparam logic [6:0] OP_SRLW   = 7'b0011001;
    localparam logic [6:0] OP_SRAW   = 7'b0011010;

    // add class
    localparam logic [6:0] OP_ADDUW  = 7'b0100000;
    localparam logic [6:0] OP_ADD    = 7'b0100001;
    localparam logic [6:0] OP_SR29   = 7'b0100100;
    localparam logic [6:0] OP_SR30   = 7'b0100101;
    localparam logic [6:0] OP_SR31   = 7'b0100110;
    localparam logic [6:0] OP_SR32   = 7'b0100111;
    localparam logic [6:0] OP_SH1UW  = 7'b0101000;
    localparam logic [6:0] OP_SH1    = 7'b0101001;
    localparam logic [6:0] OP_SH2UW  = 7'b0101010;
    localparam logic [6:0] OP_SH2    = 7'b0101011;
    localparam logic [6:0] OP_SH3UW  = 7'b0101100;
    localparam logic [6:0] OP_SH3    = 7'b0101101;
    localparam logic [6:0] OP_SH4    = 7'b0101111;

    // subtract / compare class
    localparam logic [6:0] OP_SUB    = 7'b0110000;
    localparam logic [6:0] OP_SLTU   = 7'b0110001;
    localparam logic [6:0] OP_SLT    = 7'b0110010;
    localparam logic [6:0] OP_MAXU   = 7'b0110100;
    localparam logic [6:0] OP_MINU   = 7'b0110101;
    localparam logic [6:0] OP_MAX    = 7'b0110110;
    localparam logic [6:0] OP_MIN    = 7'b0110111;

    // logic class
    localparam logic [6:0] OP_AND    = 7'b1000000;
    localparam logic [6:0] OP_ANDN   = 7'b1000001;
    localparam logic [6:0] OP_OR     = 7'b1000010;
    localparam logic [6:0] OP_ORN    = 7'b1000011;
    localparam logic [6:0] OP_XOR    = 7'b1000100;
    localparam logic [6:0] OP_XNOR   = 7'b1000101;
    localparam logic [6:0] OP_ORCB   = 7'b1000110;

    // misc class
    localparam logic [6:0] OP_SEXTB  = 7'b1001000;
    localparam logic [6:0] OP_PACKH  = 7'b1001001;
    localparam logic [6:0] OP_SEXTH  = 7'b1001010;
    localparam logic [6:0] OP_PACKW  = 7'b1001011;
    localparam logic [6:0] OP_REVB   = 7'b1010000;
    localparam logic [6:0] OP_REV8   = 7'b1010001;
    localparam logic [6:0] OP_PACK   = 7'b1010010;

endpackage

// File: rtl/bmu_shift.sv
module bmu_shift #(
    parameter int XLEN = 64
) (
    input  logic [6:0]      op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res,
    output logic            hit
);
    import bmu_pkg::*;

    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0]  amt;
    logic [SHW-1:0]  amt_neg;
    logic [XLEN-1:0] a_lo;
    logic [XLEN-1:0] bit_mask;

    assign amt      = b[SHW-1:0];
    assign amt_neg  = ~amt + SHW'(1);
    assign a_lo     = {{(XLEN-32){1'b0}}, a[31:0]};
    assign bit_mask = {{(XLEN-1){1'b0}}, 1'b1} << amt;

    always_comb begin
        res = '0;
        hit = 1'b1;
        unique case (op)
            OP_SLLIUW: res = a_lo << amt;
            OP_SLL:    res = a << amt;
            OP_BCLR:   res = a & ~bit_mask;
            OP_BSET:   res = a | bit_mask;
            OP_BINV:   res = a ^ bit_mask;
            OP_SRL:    res = a >> amt;
            OP_BEXT:   res = {{(XLEN-1){1'b0}}, a[amt]};
            OP_SRA:    res = $signed(a) >>> amt;
            OP_ROL:    res = (a << amt) | (a >> amt_neg);
            OP_ROR:    res = (a >> amt) | (a << amt_neg);
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bmu_arith.sv
module bmu_arith #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic [6:0]      op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res,
    output logic            hit,
    output logic            lt_s,
    output logic            lt_u
);
    import bmu_pkg::*;

    localparam int SHW  = $clog2(XLEN);
    localparam int WSHW = $clog2(WLEN);

    function automatic logic [XLEN-1:0] sext_w(input logic [WLEN-1:0] v);
        return {{(XLEN-WLEN){v[WLEN-1]}}, v};
    endfunction

    // shared subtractor: borrow gives unsigned order, sign rule gives signed
    logic [XLEN:0]   diff_ext;
    logic [XLEN-1:0] diff;
    assign diff_ext = {1'b0, a} - {1'b0, b};
    assign diff     = diff_ext[XLEN-1:0];
    assign lt_u     = diff_ext[XLEN];
    assign lt_s     = (a[XLEN-1] != b[XLEN-1]) ? a[XLEN-1] : diff[XLEN-1];

    // word path
    logic [WLEN-1:0] wa, wb, w_sum, w_dif, w_sll, w_srl, w_sra;
    logic [WSHW-1:0] wamt;
    assign wa    = a[WLEN-1:0];
    assign wb    = b[WLEN-1:0];
    assign wamt  = b[WSHW-1:0];
    assign w_sum = wa + wb;
    assign w_dif = wa - wb;
    assign w_sll = wa << wamt;
    assign w_srl = wa >> wamt;
    assign w_sra = $signed(wa) >>> wamt;

    // add paths
    logic [XLEN-1:0] a_uw, sh_base, sh_sum, sr_sum;
    logic [2:0]      sh_n;
    logic [SHW-1:0]  sr_n;
    assign a_uw    = {{(XLEN-WLEN){1'b0}}, wa};
    assign sh_base = op[0] ? a : a_uw;
    assign sh_n    = {1'b0, op[2:1]} + 3'd1;
    assign sh_sum  = (sh_base << sh_n) + b;
    assign sr_n    = SHW'(29) + SHW'(op[1:0]);
    assign sr_sum  = (a >> sr_n) + b;

    always_comb begin
        res = '0;
        hit = 1'b1;
        unique case (op)
            OP_ADDW:  res = sext_w(w_sum);
            OP_SUBW:  res = sext_w(w_dif);
            OP_SLLW:  res = sext_w(w_sll);
            OP_SRLW:  res = sext_w(w_srl);
            OP_SRAW:  res = sext_w(w_sra);
            OP_ADDUW: res = a_uw + b;
            OP_ADD:   res = a + b;
            OP_SR29, OP_SR30, OP_SR31, OP_SR32:
                      res = sr_sum;
            OP_SH1UW, OP_SH1, OP_SH2UW, OP_SH2, OP_SH3UW, OP_SH3, OP_SH4:
                      res = sh_sum;
            OP_SUB:   res = diff;
            OP_SLTU:  res = {{(XLEN-1){1'b0}}, lt_u};
            OP_SLT:   res = {{(XLEN-1){1'b0}}, lt_s};
            OP_MAXU:  res = lt_u ? b : a;
            OP_MINU:  res = lt_u ? a : b;
            OP_MAX:   res = lt_s ? b : a;
            OP_MIN:   res = lt_s ? a : b;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bmu_logic.sv
module bmu_logic #(
    parameter int XLEN = 64
) (
    input  logic [6:0]      op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res,
    output logic            hit
);
    import bmu_pkg::*;

    localparam int NB = XLEN / 8;

    logic [XLEN-1:0] b_eff, orcb_a, rev_bytes, rev_bits, red_val;

    assign b_eff = op[0] ? ~b : b;

    for (genvar gi = 0; gi < NB; gi++) begin : g_byte
        assign orcb_a[8*gi +: 8]          = {8{|a[8*gi +: 8]}};
        assign rev_bytes[8*gi +: 8]       = a[8*(NB-1-gi) +: 8];
        for (genvar gj = 0; gj < 8; gj++) begin : g_bit
            assign rev_bits[8*gi + gj]    = a[8*gi + 7 - gj];
        end
    end

    // value reduced by class 110: bits [2:1] pick the logic function
    always_comb begin
        unique case (op[2:1])
            2'b00:   red_val = a & b;
            2'b01:   red_val = a | b;
            2'b10:   red_val = a ^ b;
            default: red_val = orcb_a;
        endcase
    end

    always_comb begin
        res = '0;
        hit = 1'b1;
        unique case (op)
            OP_AND, OP_ANDN: res = a & b_eff;
            OP_OR,  OP_ORN:  res = a | b_eff;
            OP_XOR, OP_XNOR: res = a ^ b_eff;
            OP_ORCB:         res = orcb_a;
            OP_SEXTB: res = {{(XLEN-8){a[7]}}, a[7:0]};
            OP_SEXTH: res = {{(XLEN-16){a[15]}}, a[15:0]};
            OP_PACKH: res = {{(XLEN-16){1'b0}}, b[7:0], a[7:0]};
            OP_PACKW: res = {{(XLEN-32){b[15]}}, b[15:0], a[15:0]};
            OP_REVB:  res = rev_bits;
            OP_REV8:  res = rev_bytes;
            OP_PACK:  res = {b[31:0], a[31:0]};
            7'b1100000, 7'b1100010, 7'b1100100, 7'b1100110:
                      res = {{(XLEN-1){1'b0}}, red_val[0]};
            7'b1100001, 7'b1100011, 7'b1100101, 7'b1100111:
                      res = {{(XLEN-16){1'b0}}, red_val[15:0]};
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bmu_branch.sv
module bmu_branch #(
    parameter int XLEN = 64
) (
    input  logic [6:0]      op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            lt_s,
    input  logic            lt_u,
    output logic            taken
);
    import bmu_pkg::*;

    logic cond, valid;

    assign valid = (op_class_e'(op[6:4]) == CLS_BRANCH) && !op[0] && (op[3:2] != 2'b01);

    always_comb begin
        unique case (op[3:2])
            2'b00:   cond = (a == b);
            2'b10:   cond = lt_s;
            2'b11:   cond = lt_u;
            default: cond = 1'b0;
        endcase
    end

    assign taken = valid & (cond ^ op[1]);
endmodule

// File: rtl/bmu_alu.sv
module bmu_alu #(
    parameter int XLEN = 64
) (
    input  logic [6:0]      op_code,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic [XLEN-1:0] result,
    output logic            br_taken
);
    import bmu_pkg::*;

    logic [XLEN-1:0] sh_res, ar_res, lg_res;
    logic            sh_hit, ar_hit, lg_hit, lt_s, lt_u;
    op_class_e       cls;

    assign cls = op_class_e'(op_code[6:4]);

    bmu_shift #(.XLEN(XLEN)) u_shift (
        .op(op_code), .a(src_a), .b(src_b), .res(sh_res), .hit(sh_hit)
    );

    bmu_arith #(.XLEN(XLEN), .WLEN(32)) u_arith (
        .op(op_code), .a(src_a), .b(src_b), .res(ar_res), .hit(ar_hit),
        .lt_s(lt_s), .lt_u(lt_u)
    );

    bmu_logic #(.XLEN(XLEN)) u_logic (
        .op(op_code), .a(src_a), .b(src_b), .res(lg_res), .hit(lg_hit)
    );

    bmu_branch #(.XLEN(XLEN)) u_branch (
        .op(op_code), .a(src_a), .b(src_b), .lt_s(lt_s), .lt_u(lt_u),
        .taken(br_taken)
    );

    always_comb begin
        unique case (cls)
            CLS_SHIFT:                      result = sh_hit ? sh_res : '0;
            CLS_WORD, CLS_ADD, CLS_SUB:     result = ar_hit ? ar_res : '0;
            CLS_LOGIC, CLS_MISC, CLS_REDUCE: result = lg_hit ? lg_res : '0;
            default:                        result = '0;
        endcase
    end
endmodule

// File: rtl/bmu_alu_chk.sv
module bmu_alu_chk #(
    parameter int XLEN = 64
) (
    input logic [6:0]      op_code,
    input logic [XLEN-1:0] src_a,
    input logic [XLEN-1:0] src_b,
    input logic [XLEN-1:0] result,
    input logic            br_taken
);
    always_comb begin
        if (!$isunknown({op_code, src_a, src_b})) begin
            if (op_code[6:4] != 3'b111)
                p_flag_only_branch_r11: assert (!br_taken);
            if (op_code[6:4] == 3'b111)
                p_branch_result_zero_r11: assert (result == '0);
            if (op_code[6:4] == 3'b001)
                p_word_sext_r3: assert (result[XLEN-1:31] == '0 || result[XLEN-1:31] == '1);
            if (op_code == 7'b0000110)
                p_bext_single_r2: assert (result[XLEN-1:1] == '0);
            if (op_code[6:4] == 3'b110 && !op_code[0])
                p_reduce_lsb_r9: assert (result[XLEN-1:1] == '0);
            if (op_code[6:4] == 3'b110 && op_code[0])
                p_reduce_half_r9: assert (result[XLEN-1:16] == '0);
            if (op_code == 7'b0110001 || op_code == 7'b0110010)
                p_compare_bool_r6: assert (result[XLEN-1:1] == '0);
            if (op_code == 7'b1110000)
                p_beq_match_r10: assert (br_taken == (src_a == src_b));
        end
    end
endmodule

bind bmu_alu bmu_alu_chk #(.XLEN(XLEN)) u_chk (
    .op_code(op_code), .src_a(src_a), .src_b(src_b),
    .result(result), .br_taken(br_taken)
);

// File: tb/bmu_alu_tb.sv
module bmu_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  op_code = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] result;
    logic        br_taken;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;
    logic [63:0] corner [8];

    always #5 clk = ~clk;

    bmu_alu #(.XLEN(64)) u_dut (
        .op_code(op_code), .src_a(src_a), .src_b(src_b),
        .result(result), .br_taken(br_taken)
    );

    function automatic logic [63:0] orcb64(input logic [63:0] v);
        logic [63:0] o;
        for (int i = 0; i < 8; i++) o[8*i +: 8] = (v[8*i +: 8] != 0) ? 8'hFF : 8'h00;
        return o;
    endfunction

    function automatic logic [63:0] sx32(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    function automatic void model(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b,
                                  output logic [63:0] r, output logic t, output logic known);
        logic [5:0]   s6;
        logic [4:0]   s5;
        logic [127:0] dbl;
        logic [63:0]  ua, o;
        s6 = b[5:0];
        s5 = b[4:0];
        ua = {32'h0, a[31:0]};
        r = '0; t = 1'b0; known = 1'b1;
        case (op)
            7'b0000000: r = ua << s6;
            7'b0000001: r = a << s6;
            7'b0000010: r = a & ~(64'd1 << s6);
            7'b0000011: r = a | (64'd1 << s6);
            7'b0000100: r = a ^ (64'd1 << s6);
            7'b0000101: r = a >> s6;
            7'b0000110: r = {63'd0, a[s6]};
            7'b0000111: r = $signed(a) >>> s6;
            7'b0001001: begin dbl = {a, a} << s6; r = dbl[127:64]; end
            7'b0001011: begin dbl = {a, a} >> s6; r = dbl[63:0]; end
            7'b0010000: r = sx32(a[31:0] + b[31:0]);
            7'b0010010: r = sx32(a[31:0] - b[31:0]);
            7'b0011000: r = sx32(a[31:0] << s5);
            7'b0011001: r = sx32(a[31:0] >> s5);
            7'b0011010: r = sx32($signed(a[31:0]) >>> s5);
            7'b0100000: r = ua + b;
            7'b0100001: r = a + b;
            7'b0100100: r = (a >> 29) + b;
            7'b0100101: r = (a >> 30) + b;
            7'b0100110: r = (a >> 31) + b;
            7'b0100111: r = (a >> 32) + b;
            7'b0101000: r = ua * 2 + b;
            7'b0101001: r = a * 2 + b;
            7'b0101010: r = ua * 4 + b;
            7'b0101011: r = a * 4 + b;
            7'b0101100: r = ua * 8 + b;
            7'b0101101: r = a * 8 + b;
            7'b0101111: r = a * 16 + b;
            7'b0110000: r = a - b;
            7'b0110001: r = (a < b) ? 64'd1 : 64'd0;
            7'b0110010: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
            7'b0110100: r = (a > b) ? a : b;
            7'b0110101: r = (a < b) ? a : b;
            7'b0110110: r = ($signed(a) > $signed(b)) ? a : b;
            7'b0110111: r = ($signed(a) < $signed(b)) ? a : b;
            7'b1000000: r = a & b;
            7'b1000001: r = a & ~b;
            7'b1000010: r = a | b;
            7'b1000011: r = a | ~b;
            7'b1000100: r = a ^ b;
            7'b1000101: r = ~(a ^ b);
            7'b1000110: r = orcb64(a);
            7'b1001000: r = {{56{a[7]}}, a[7:0]};
            7'b1001001: r = {48'd0, b[7:0], a[7:0]};
            7'b1001010: r = {{48{a[15]}}, a[15:0]};
            7'b1001011: r = sx32({b[15:0], a[15:0]});
            7'b1010000: for (int i = 0; i < 64; i++) r[i] = a[(i & ~7) + (7 - (i & 7))];
            7'b1010001: for (int i = 0; i < 8; i++) r[8*i +: 8] = a[8*(7-i) +: 8];
            7'b1010010: r = {b[31:0], a[31:0]};
            7'b1100000: r = {63'd0, a[0] & b[0]};
            7'b1100001: r = {48'd0, a[15:0] & b[15:0]};
            7'b1100010: r = {63'd0, a[0] | b[0]};
            7'b1100011: r = {48'd0, a[15:0] | b[15:0]};
            7'b1100100: r = {63'd0, a[0] ^ b[0]};
            7'b1100101: r = {48'd0, a[15:0] ^ b[15:0]};
            7'b1100110: r = {63'd0, |a[7:0]};
            7'b1100111: begin o = orcb64(a); r = {48'd0, o[15:0]}; end
            7'b1110000: t = (a == b);
            7'b1110010: t = (a != b);
            7'b1111000: t = $signed(a) < $signed(b);
            7'b1111010: t = $signed(a) >= $signed(b);
            7'b1111100: t = a < b;
            7'b1111110: t = a >= b;
            default:    known = 1'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [6:0] op);
        case (op[6:4])
            3'b000:  return (op >= 7'b0000010 && op <= 7'b0000110 && op != 7'b0000101) ? "R2" : "R1";
            3'b001:  return "R3";
            3'b010:  return (op[3:2] == 2'b01) ? "R5" : "R4";
            3'b011:  return "R6";
            3'b100:  return "R7";
            3'b101:  return "R8";
            3'b110:  return "R9";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp,
                         input logic [6:0] op);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, src_a, src_b, got, exp);
        end
    endtask

    task automatic run_vec(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] er;
        logic        et, kn;
        @(posedge clk);
        op_code = op; src_a = a; src_b = b;
        @(negedge clk);
        model(op, a, b, er, et, kn);
        check(kn ? (op[6:4] == 3'b111 ? "R11" : req_of(op)) : "R12", result, er, op);
        check(kn ? (op[6:4] == 3'b111 ? "R10" : "R11") : "R12", {63'd0, br_taken}, {63'd0, et}, op);
    endtask

    // compare result and branch flag come from the same subtractor
    task automatic pair_check(input logic [63:0] a, input logic [63:0] b);
        logic slt_bit, sltu_bit;
        @(posedge clk); op_code = 7'b0110010; src_a = a; src_b = b;
        @(negedge clk); slt_bit = result[0];
        @(posedge clk); op_code = 7'b1111000;
        @(negedge clk); check("R10 blt-vs-slt", {63'd0, br_taken}, {63'd0, slt_bit}, op_code);
        @(posedge clk); op_code = 7'b1111010;
        @(negedge clk); check("R10 bge-vs-slt", {63'd0, br_taken}, {63'd0, ~slt_bit}, op_code);
        @(posedge clk); op_code = 7'b0110001;
        @(negedge clk); sltu_bit = result[0];
        @(posedge clk); op_code = 7'b1111100;
        @(negedge clk); check("R10 bltu-vs-sltu", {63'd0, br_taken}, {63'd0, sltu_bit}, op_code);
        @(posedge clk); op_code = 7'b1111110;
        @(negedge clk); check("R10 bgeu-vs-sltu", {63'd0, br_taken}, {63'd0, ~sltu_bit}, op_code);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        corner[0] = 64'h0;
        corner[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        corner[2] = 64'h8000_0000_0000_0000;
        corner[3] = 64'h7FFF_FFFF_FFFF_FFFF;
        corner[4] = 64'h0000_0000_8000_0000;
        corner[5] = 64'h0000_0000_0000_0021;
        corner[6] = 64'h0123_4567_89AB_CDEF;
        corner[7] = 64'hFFFF_FFFF_FFFF_FFDF;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // idle state: opcode 0 with zero operands gives zero outputs (R1, R11)
        @(negedge clk);
        check("R1 idle result", result, 64'd0, op_code);
        check("R11 idle flag", {63'd0, br_taken}, 64'd0, op_code);

        // every opcode over the corner grid
        for (int o = 0; o < 128; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run_vec(7'(o), corner[i], corner[j]);

        // every opcode over pseudo-random pairs, some sharing operands
        for (int k = 0; k < 24; k++) begin
            logic [63:0] ra, rb;
            seed = next_rand(seed); ra = seed;
            seed = next_rand(seed); rb = (k % 6 == 0) ? ra : seed;
            for (int o = 0; o < 128; o++) run_vec(7'(o), ra, rb);
            pair_check(ra, rb);
        end
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                pair_check(corner[i], corner[j]);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule